// File: doc/BRIEF.md
# Memory Frequency Boost Governor

This block is a hardware governor for one memory clock domain. It is fed by several activity-monitor channels. Each channel reports an averaged activity count together with an optional event: the count has stayed above its watermark for some consecutive samples, or it has stayed below it. For the channel that reported, the governor keeps a boost value in kHz. An upper event grows the boost by a multiplicative factor plus a fixed step. A lower event shrinks it by another factor. The governor also decides whether the monitor should keep each consecutive-event direction armed.

For each event the block also computes the values the monitor and the clock controller need next. These are the raw watermarks derived from the current frequency, the average watermarks placed around the new average, and the channel's target frequency. The target combines the average, the boost and an optional floor derived from the CPU frequency. The block keeps the last target of every channel and presents the highest one as the frequency request.

The divisions run on one shared multi-cycle sequential divider. An event is accepted only while the block is idle. A one-cycle `done` strobe marks the point where the results are valid.

Top module: `boost_gov`

## Requirements
- R1: Event kind 1 (upper) sets the channel boost to boost*up_coeff/100 + 16000. If that value is at or above max_khz, the boost becomes max_khz and arm_above is 0; otherwise arm_above is 1. arm_below is set to 1.
- R2: Event kind 2 (lower) sets the boost to boost*down_coeff/100. If that value is below 8000, the boost becomes 0 and arm_below is 0; otherwise arm_below is 1. arm_above is set to 1.
- R3: Event kinds 0 and 3 leave the channel's boost and both arm bits as they were, subject only to R4.
- R4: This rule applies only to a channel whose dependency threshold is nonzero. If avg_count is at or above that threshold, arm_below is forced to 1. Otherwise, if the new boost is 0, arm_below is forced to 0.
- R5: chan_target = ((avg_count/12) * (10000/up_threshold))/100 + boost, with every division truncating.
- R6: When avg_count is at or above the channel's dependency threshold, chan_target is the larger of the R5 value and a CPU floor. The floor is 0 for a channel whose threshold is 0. Otherwise the floor comes from cpu_khz, checked from the top entry down: at or above 1400000 gives max_khz; 1200000 gives 750000; 1100000 gives 600000; 1000000 gives 500000; 800000 gives 375000; 500000 gives 200000; 250000 gives 100000; anything lower gives 0. The result is capped at max_khz.
- R7: wm_hi = cur_khz*12*up_threshold/100 and wm_lo = cur_khz*12*down_threshold/100.
- R8: With band = (max_khz*6/1000)*12, avg_wm_hi = avg_count + band and avg_wm_lo = max(avg_count, band) - band, so avg_wm_lo never drops below zero.
- R9: req_khz is the largest of the most recent chan_target values of all channels.
- R10: Channel 0 uses coefficients 200/50, thresholds 60/40 and no dependency threshold. Channel 1 uses coefficients 800/90, thresholds 27/10 and a dependency threshold of 50000.
- R11: An event is taken only when ev_valid is high and busy is low. done pulses for exactly one cycle, while busy is low. An ev_valid that arrives while busy is high has no effect on any channel.
- R12: After reset every output is 0 and busy is low. Every channel starts with a boost of 0 and both arm bits set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Start processing an event (taken only when idle) |
| ev_chan | input | 1 | Channel index |
| ev_kind | input | 2 | 0 none, 1 upper, 2 lower, 3 none |
| avg_count | input | 32 | Averaged activity count of the channel |
| cur_khz | input | 32 | Current memory frequency |
| max_khz | input | 32 | Maximum memory frequency |
| cpu_khz | input | 32 | CPU frequency for the floor lookup |
| busy | output | 1 | Event being processed |
| done | output | 1 | One-cycle strobe; results valid |
| boost_out | output | 32 | New boost of the processed channel |
| arm_above | output | 1 | New upper-direction arm bit |
| arm_below | output | 1 | New lower-direction arm bit |
| wm_hi | output | 32 | Raw upper watermark |
| wm_lo | output | 32 | Raw lower watermark |
| avg_wm_hi | output | 32 | Average upper watermark |
| avg_wm_lo | output | 32 | Average lower watermark |
| chan_target | output | 32 | Target frequency of the processed channel |
| req_khz | output | 32 | Maximum target over all channels |

## Verification
On every cycle the assertions check the strobe protocol. They also check that the latched channel stays fixed while the block is busy and that an upper result never exceeds the maximum frequency. A lower result is checked to be either zero or at least half the step. The saturation arm bit must agree with the clamp. The lower average mark must not exceed the average, and the request must cover the channel target. The exact arithmetic needs the bench's scenarios: the growth to saturation and the decay to zero, the CPU floor table, the dependency override of the lower arm, the per-channel presets, the band floor at zero, and an event that is ignored because it arrives while busy.

// File: rtl/boost_gov_pkg.sv
// Shared types and per-channel presets of the boost governor.
// Assumes channel indices wrap modulo the number of presets.
package boost_gov_pkg;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_UPPER = 2'd1,
        EV_LOWER = 2'd2,
        EV_RSVD  = 2'd3
    } ev_kind_t;

    typedef struct packed {
        logic [15:0] up_c;
        logic [15:0] dn_c;
        logic [15:0] up_t;
        logic [15:0] dn_t;
        logic [15:0] sust;
        logic [31:0] dep;
    } chan_cfg_t;

    // Preset coefficients of one channel; sust is 10000/up_t.
    function automatic chan_cfg_t chan_cfg(input logic ch);
        chan_cfg_t c;
        if (ch) begin
            c.up_c = 16'd800;  c.dn_c = 16'd90;
            c.up_t = 16'd27;   c.dn_t = 16'd10;
            c.sust = 16'(10000 / 27);
            c.dep  = 32'd50000;
        end else begin
            c.up_c = 16'd200;  c.dn_c = 16'd50;
            c.up_t = 16'd60;   c.dn_t = 16'd40;
            c.sust = 16'(10000 / 60);
            c.dep  = 32'd0;
        end
        return c;
    endfunction

endpackage

// File: rtl/boost_div_seq.sv
// Restoring radix-2 unsigned divider, one quotient bit per cycle.
// Assumes a nonzero divisor; done pulses one cycle after the last bit.
module boost_div_seq #(
    parameter int DW = 48,
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] quotient
);
    localparam int CNTW = $clog2(DW + 1);

    logic [DW-1:0]   quo_q;
    logic [VW-1:0]   rem_q;
    logic [CNTW-1:0] cnt_q;
    logic            run_q;
    logic            done_q;
    logic [VW:0]     trial;
    logic [VW:0]     diff;
    logic            ge;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        trial = {rem_q, quo_q[DW-1]};
        diff  = trial - {1'b0, divisor};
        ge    = (trial >= {1'b0, divisor});
    end

    // Iteration state: load on start, then shift one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                quo_q <= dividend;
                rem_q <= '0;
                cnt_q <= CNTW'(DW);
                run_q <= 1'b1;
            end else if (run_q) begin
                quo_q <= {quo_q[DW-2:0], ge};
                rem_q <= ge ? diff[VW-1:0] : trial[VW-1:0];
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNTW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done     = done_q;
    assign quotient = quo_q;
endmodule

// File: rtl/boost_floor_lut.sv
// CPU-derived floor: descending threshold search, capped at the maximum.
// Assumes frequencies in kHz.
module boost_floor_lut #(
    parameter int FW = 32
) (
    input  logic [FW-1:0] cpu_khz,
    input  logic [FW-1:0] max_khz,
    output logic [FW-1:0] floor_khz
);
    logic [FW-1:0] raw;

    // First entry whose CPU threshold is at or below the CPU frequency.
    always_comb begin
        if      (cpu_khz >= FW'(1400000)) raw = max_khz;
        else if (cpu_khz >= FW'(1200000)) raw = FW'(750000);
        else if (cpu_khz >= FW'(1100000)) raw = FW'(600000);
        else if (cpu_khz >= FW'(1000000)) raw = FW'(500000);
        else if (cpu_khz >= FW'(800000))  raw = FW'(375000);
        else if (cpu_khz >= FW'(500000))  raw = FW'(200000);
        else if (cpu_khz >= FW'(250000))  raw = FW'(100000);
        else                               raw = '0;
        floor_khz = (raw >= max_khz) ? max_khz : raw;
    end
endmodule

// File: rtl/boost_rule.sv
// Boost growth/decay clamps and arm-bit decisions for one event.
// Assumes scaled = boost*coeff/100 for the coefficient of the event kind.
module boost_rule
    import boost_gov_pkg::*;
#(
    parameter int FW   = 32,
    parameter int DW   = 48,
    parameter int STEP = 16000
) (
    input  ev_kind_t      kind,
    input  logic [DW-1:0] scaled,
    input  logic [FW-1:0] boost_in,
    input  logic [FW-1:0] max_khz,
    input  logic          arm_a_in,
    input  logic          arm_b_in,
    input  logic [FW-1:0] dep,
    input  logic [FW-1:0] avg,
    output logic [FW-1:0] boost_new,
    output logic          arm_a,
    output logic          arm_b
);
    localparam int HALF = STEP / 2;

    logic [DW-1:0] grown;

    // Apply the event, then the dependency override of the lower arm.
    always_comb begin
        grown     = scaled + DW'(STEP);
        boost_new = boost_in;
        arm_a     = arm_a_in;
        arm_b     = arm_b_in;
        case (kind)
            EV_UPPER: begin
                arm_b = 1'b1;
                if (grown >= DW'(max_khz)) begin
                    boost_new = max_khz;
                    arm_a     = 1'b0;
                end else begin
                    boost_new = FW'(grown);
                    arm_a     = 1'b1;
                end
            end
            EV_LOWER: begin
                arm_a = 1'b1;
                if (scaled < DW'(HALF)) begin
                    boost_new = '0;
                    arm_b     = 1'b0;
                end else begin
                    boost_new = FW'(scaled);
                    arm_b     = 1'b1;
                end
            end
            default: ;
        endcase
        if (dep != '0) begin
            if (avg >= dep)             arm_b = 1'b1;
            else if (boost_new == '0)   arm_b = 1'b0;
        end
    end
endmodule

// File: rtl/boost_gov.sv
// Boost governor top: latches an event, runs six divisions on a shared
// sequential divider, then updates channel state and all outputs at once.
// Assumes inputs stay meaningful only at the accepting cycle (latched).
module boost_gov
    import boost_gov_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int FW          = 32,
    parameter int DW          = 48,
    parameter int VW          = 16,
    parameter int PERIOD      = 12,
    parameter int STEP        = 16000,
    parameter int BAND_PERMIL = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    input  logic          ev_chan,
    input  logic [1:0]    ev_kind,
    input  logic [FW-1:0] avg_count,
    input  logic [FW-1:0] cur_khz,
    input  logic [FW-1:0] max_khz,
    input  logic [FW-1:0] cpu_khz,
    output logic          busy,
    output logic          done,
    output logic [FW-1:0] boost_out,
    output logic          arm_above,
    output logic          arm_below,
    output logic [FW-1:0] wm_hi,
    output logic [FW-1:0] wm_lo,
    output logic [FW-1:0] avg_wm_hi,
    output logic [FW-1:0] avg_wm_lo,
    output logic [FW-1:0] chan_target,
    output logic [FW-1:0] req_khz
);
    localparam int NOPS = 6;
    localparam int OPW  = $clog2(NOPS);

    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_FIN} state_t;

    state_t        state_q;
    logic [OPW-1:0] op_q;
    logic          ch_q;
    logic [1:0]    kind_q;
    logic [FW-1:0] avg_q, cur_q, max_q, cpu_q;
    logic [DW-1:0] res_q [NOPS];
    logic          done_q;

    logic [FW-1:0] boost_q [NCH];
    logic          arm_a_q [NCH];
    logic          arm_b_q [NCH];
    logic [FW-1:0] tgt_q   [NCH];

    chan_cfg_t     cfg;
    logic [DW-1:0] dvd;
    logic [VW-1:0] dvs;
    logic          div_done;
    logic [DW-1:0] quo;
    logic [FW-1:0] floor_khz;
    logic [FW-1:0] boost_new;
    logic          arm_a_new, arm_b_new;
    logic [FW-1:0] band, avg_top, tgt_new;
    logic [DW-1:0] tgt_sum;

    assign cfg = chan_cfg(ch_q);

    // Operand selection for the division step in progress.
    always_comb begin
        dvd = '0;
        dvs = VW'(100);
        case (op_q)
            OPW'(0): dvd = DW'(boost_q[ch_q]) *
                           DW'((kind_q == EV_UPPER) ? cfg.up_c : cfg.dn_c);
            OPW'(1): begin dvd = DW'(avg_q); dvs = VW'(PERIOD); end
            OPW'(2): dvd = res_q[1] * DW'(cfg.sust);
            OPW'(3): dvd = DW'(cur_q) * DW'(PERIOD) * DW'(cfg.up_t);
            OPW'(4): dvd = DW'(cur_q) * DW'(PERIOD) * DW'(cfg.dn_t);
            default: begin dvd = DW'(max_q) * DW'(BAND_PERMIL); dvs = VW'(1000); end
        endcase
    end

    boost_div_seq #(.DW(DW), .VW(VW)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (state_q == S_LOAD),
        .dividend (dvd),
        .divisor  (dvs),
        .done     (div_done),
        .quotient (quo)
    );

    boost_floor_lut #(.FW(FW)) floor_i (
        .cpu_khz   (cpu_q),
        .max_khz   (max_q),
        .floor_khz (floor_khz)
    );

    boost_rule #(.FW(FW), .DW(DW), .STEP(STEP)) rule_i (
        .kind      (ev_kind_t'(kind_q)),
        .scaled    (res_q[0]),
        .boost_in  (boost_q[ch_q]),
        .max_khz   (max_q),
        .arm_a_in  (arm_a_q[ch_q]),
        .arm_b_in  (arm_b_q[ch_q]),
        .dep       (cfg.dep),
        .avg       (avg_q),
        .boost_new (boost_new),
        .arm_a     (arm_a_new),
        .arm_b     (arm_b_new)
    );

    // Final combination: band, average marks, target with optional floor.
    always_comb begin
        band    = FW'(res_q[5]) * FW'(PERIOD);
        avg_top = (avg_q > band) ? avg_q : band;
        tgt_sum = res_q[2] + DW'(boost_new);
        tgt_new = FW'(tgt_sum);
        if (cfg.dep != '0 && avg_q >= cfg.dep && floor_khz > tgt_new)
            tgt_new = floor_khz;
    end

    // Sequencer: accept when idle, step through divisions, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= '0;
            ch_q    <= 1'b0;
            kind_q  <= '0;
            avg_q   <= '0;
            cur_q   <= '0;
            max_q   <= '0;
            cpu_q   <= '0;
            done_q  <= 1'b0;
            for (int i = 0; i < NOPS; i++) res_q[i] <= '0;
        end else begin
            done_q <= (state_q == S_FIN);
            case (state_q)
                S_IDLE: if (ev_valid) begin
                    ch_q    <= ev_chan;
                    kind_q  <= ev_kind;
                    avg_q   <= avg_count;
                    cur_q   <= cur_khz;
                    max_q   <= max_khz;
                    cpu_q   <= cpu_khz;
                    op_q    <= '0;
                    state_q <= S_LOAD;
                end
                S_LOAD: state_q <= S_RUN;
                S_RUN: if (div_done) begin
                    res_q[op_q] <= quo;
                    if (op_q == OPW'(NOPS - 1)) state_q <= S_FIN;
                    else begin
                        op_q    <= op_q + 1'b1;
                        state_q <= S_LOAD;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Result registers presented with the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boost_out   <= '0;
            arm_above   <= 1'b0;
            arm_below   <= 1'b0;
            wm_hi       <= '0;
            wm_lo       <= '0;
            avg_wm_hi   <= '0;
            avg_wm_lo   <= '0;
            chan_target <= '0;
        end else if (state_q == S_FIN) begin
            boost_out   <= boost_new;
            arm_above   <= arm_a_new;
            arm_below   <= arm_b_new;
            wm_hi       <= FW'(res_q[3]);
            wm_lo       <= FW'(res_q[4]);
            avg_wm_hi   <= avg_q + band;
            avg_wm_lo   <= avg_top - band;
            chan_target <= tgt_new;
        end
    end

    // Per-channel state, written only for the processed channel.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                boost_q[c] <= '0;
                arm_a_q[c] <= 1'b1;
                arm_b_q[c] <= 1'b1;
                tgt_q[c]   <= '0;
            end else if (state_q == S_FIN && ch_q == 1'(c)) begin
                boost_q[c] <= boost_new;
                arm_a_q[c] <= arm_a_new;
                arm_b_q[c] <= arm_b_new;
                tgt_q[c]   <= tgt_new;
            end
        end
    end

    // Request is the largest stored channel target.
    always_comb begin
        req_khz = '0;
        for (int i = 0; i < NCH; i++)
            if (tgt_q[i] > req_khz) req_khz = tgt_q[i];
    end

    assign busy = (state_q != S_IDLE);
    assign done = done_q;
endmodule

// File: rtl/boost_gov_chk.sv
// Protocol and invariant checker for the boost governor, bound to the top.
module boost_gov_chk #(
    parameter int FW   = 32,
    parameter int STEP = 16000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          ch_q,
    input logic [1:0]    kind_q,
    input logic [FW-1:0] max_q,
    input logic [FW-1:0] avg_q,
    input logic [FW-1:0] boost_out,
    input logic          arm_above,
    input logic [FW-1:0] avg_wm_lo,
    input logic [FW-1:0] chan_target,
    input logic [FW-1:0] req_khz
);
    // R11: strobe only when idle
    p_idle_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R11: strobe is one cycle wide
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11: accepted channel is held while busy
    p_hold_chan_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ch_q));
    // R1: an upper result never exceeds the maximum
    p_boost_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q == 2'd1) |-> boost_out <= max_q);
    // R1: upper arm is dropped exactly when saturated
    p_sat_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q == 2'd1) |-> (arm_above == (boost_out < max_q)));
    // R2: a lower result is zero or at least half a step
    p_decay_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q == 2'd2) |-> (boost_out == '0 || boost_out >= FW'(STEP / 2)));
    // R8: lower average mark never above the average
    p_avg_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> avg_wm_lo <= avg_q);
    // R9: request covers the processed channel target
    p_req_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_khz >= chan_target);
endmodule

bind boost_gov boost_gov_chk #(.FW(FW), .STEP(STEP)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .ch_q        (ch_q),
    .kind_q      (kind_q),
    .max_q       (max_q),
    .avg_q       (avg_q),
    .boost_out   (boost_out),
    .arm_above   (arm_above),
    .avg_wm_lo   (avg_wm_lo),
    .chan_target (chan_target),
    .req_khz     (req_khz)
);

// File: tb/boost_gov_tb_top.sv
`timescale 1ns/1ps
module boost_gov_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_chan = 1'b0;
    logic [1:0]  ev_kind = 2'd0;
    logic [31:0] avg_count = '0, cur_khz = '0, max_khz = '0, cpu_khz = '0;
    logic        busy, done, arm_above, arm_below;
    logic [31:0] boost_out, wm_hi, wm_lo, avg_wm_hi, avg_wm_lo, chan_target, req_khz;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    boost_gov dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_chan(ev_chan),
        .ev_kind(ev_kind), .avg_count(avg_count), .cur_khz(cur_khz),
        .max_khz(max_khz), .cpu_khz(cpu_khz), .busy(busy), .done(done),
        .boost_out(boost_out), .arm_above(arm_above), .arm_below(arm_below),
        .wm_hi(wm_hi), .wm_lo(wm_lo), .avg_wm_hi(avg_wm_hi),
        .avg_wm_lo(avg_wm_lo), .chan_target(chan_target), .req_khz(req_khz)
    );

    typedef struct {
        longint boost, aa, ab, wh, wl, awh, awl, tgt, req;
        int     kind;
    } exp_t;

    exp_t   exp_q[$];
    longint m_boost [2] = '{0, 0};
    longint m_aa    [2] = '{1, 1};
    longint m_ab    [2] = '{1, 1};
    longint m_tgt   [2] = '{0, 0};

    task automatic chk(string tag, string what, longint act, longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Floor table written from R6.
    function automatic longint floor_of(longint cpu, longint mx);
        longint r;
        if      (cpu >= 1400000) r = mx;
        else if (cpu >= 1200000) r = 750000;
        else if (cpu >= 1100000) r = 600000;
        else if (cpu >= 1000000) r = 500000;
        else if (cpu >= 800000)  r = 375000;
        else if (cpu >= 500000)  r = 200000;
        else if (cpu >= 250000)  r = 100000;
        else                     r = 0;
        return (r > mx) ? mx : r;
    endfunction

    // Reference model from R1..R10; updates the model state.
    function automatic exp_t model(int ch, int kind, longint avg, longint cur,
                                   longint mx, longint cpu);
        exp_t e;
        longint uc, dc, ut, dt, dep, b, nb, aa, ab, t, band, fl;
        // R10 presets
        if (ch == 1) begin uc = 800; dc = 90; ut = 27; dt = 10; dep = 50000; end
        else         begin uc = 200; dc = 50; ut = 60; dt = 40; dep = 0;     end
        b = m_boost[ch]; aa = m_aa[ch]; ab = m_ab[ch]; nb = b;
        if (kind == 1) begin
            nb = b * uc / 100 + 16000; ab = 1;
            if (nb >= mx) begin nb = mx; aa = 0; end else aa = 1;
        end else if (kind == 2) begin
            nb = b * dc / 100; aa = 1;
            if (nb < 8000) begin nb = 0; ab = 0; end else ab = 1;
        end
        if (dep != 0) begin
            if (avg >= dep) ab = 1;
            else if (nb == 0) ab = 0;
        end
        t  = (avg / 12) * (10000 / ut) / 100 + nb;
        fl = (dep != 0) ? floor_of(cpu, mx) : 0;
        if (avg >= dep && fl > t) t = fl;
        band = (mx * 6 / 1000) * 12;
        m_boost[ch] = nb; m_aa[ch] = aa; m_ab[ch] = ab; m_tgt[ch] = t;
        e.boost = nb; e.aa = aa; e.ab = ab; e.tgt = t; e.kind = kind;
        e.wh  = cur * 12 * ut / 100;
        e.wl  = cur * 12 * dt / 100;
        e.awh = avg + band;
        e.awl = ((avg > band) ? avg : band) - band;
        e.req = (m_tgt[0] > m_tgt[1]) ? m_tgt[0] : m_tgt[1];
        return e;
    endfunction

    // Monitor: pops the expected item on each done strobe and compares.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                string bt;
                e  = exp_q.pop_front();
                bt = (e.kind == 1) ? "R1" : (e.kind == 2) ? "R2" : "R3";
                chk(bt,   "boost",     boost_out,   e.boost);
                chk("R4", "arm_above", arm_above,   e.aa);
                chk("R4", "arm_below", arm_below,   e.ab);
                chk("R7", "wm_hi",     wm_hi,       e.wh);
                chk("R7", "wm_lo",     wm_lo,       e.wl);
                chk("R8", "avg_wm_hi", avg_wm_hi,   e.awh);
                chk("R8", "avg_wm_lo", avg_wm_lo,   e.awl);
                chk("R5", "target",    chan_target, e.tgt);
                chk("R9", "request",   req_khz,     e.req);
                chk("R11", "busy_at_done", busy, 0);
            end
        end
    end

    // Driver: push expectation, issue event, optionally poke while busy.
    task automatic send(int ch, int kind, longint avg, longint cur, longint cpu,
                        bit poke);
        exp_q.push_back(model(ch, kind, avg, cur, 800000, cpu));
        @(negedge clk);
        ev_valid = 1'b1; ev_chan = 1'(ch); ev_kind = 2'(kind);
        avg_count = 32'(avg); cur_khz = 32'(cur); max_khz = 32'd800000;
        cpu_khz = 32'(cpu);
        @(negedge clk);
        ev_valid = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            // R11: event while busy must be dropped
            ev_valid = 1'b1; ev_chan = ~ev_chan; ev_kind = 2'd1;
            avg_count = 32'd99999;
            @(negedge clk);
            ev_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "busy",    busy,      0);
        chk("R12", "done",    done,      0);
        chk("R12", "boost",   boost_out, 0);
        chk("R12", "request", req_khz,   0);
        chk("R12", "target",  chan_target, 0);
        // R12/R3: first no-event shows both arms set; avg below band (R8)
        send(0, 0, 24000, 400000, 0, 0);
        // R1: channel 0 grows to saturation at the maximum
        for (int i = 0; i < 6; i++) send(0, 1, 480000, 400000 + i * 1000, 0, 0);
        // R2: decay down to zero, then again at zero
        for (int i = 0; i < 8; i++) send(0, 2, 36000 + i * 500, 300000, 0, 0);
        // R3: reserved kind acts as no event
        send(0, 3, 120000, 250000, 0, 0);
        // R10, R6, R4: channel 1 with floor from the CPU table
        send(1, 1, 60000, 500000, 1100000, 0);
        send(1, 0, 70000, 500000, 1500000, 0);
        send(1, 0, 55000, 500000, 240000, 0);
        // R4: channel 1 decays below the dependency threshold
        for (int i = 0; i < 9; i++) send(1, 2, 1000, 200000, 1400000, 0);
        send(1, 0, 1000, 200000, 0, 0);
        // R11: poke during busy, verify nothing else happens
        send(0, 1, 90000, 600000, 0, 1);
        repeat (400) @(negedge clk);
        send(1, 0, 52000, 600000, 800000, 0);
        // R9: request follows the larger channel
        send(0, 2, 240000, 700000, 0, 0);
        send(1, 1, 50000, 700000, 1000000, 0);
        chk("R11", "queue_drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule